// File: doc/BRIEF.md
# Two-Wire Register-Pointer Slave with Counter Snapshot

This block is a two-wire (I2C) slave that answers at one fixed 7-bit address and gives a bus master access to a small byte-wide register bank. SCL and SDA are oversampled by the system clock through synchronizers. START, repeated START and STOP are recognised, and bytes are shifted MSB first with a ninth acknowledge bit. SDA is driven only as an open-drain pull-down enable.

In a write transfer, the first byte after the address loads an internal pointer and is not stored. Every further byte lands in the register the pointer selects, and the pointer then steps on. A read is done in one of two ways. The master can write a pointer, issue a repeated START and then read. It can also start a read directly, and the bytes then come from the pointer left over from earlier traffic.

The bank holds a free-running counter, made of one byte per parameterised count lane, followed by a control byte. The counter steps on an external tick input while control bit 0 is set. A read that begins freezes a shadow copy of the counter, so a multi-byte read returns one coherent value.

Top module: `i2cp_slave`

## Requirements
- R1: A byte of 7'b1101000 followed by a direction bit (0 = write, 1 = read) is acknowledged by pulling SDA low through the whole high phase of the ninth SCL pulse.
- R2: An address byte that does not match gets no acknowledge. All later bytes are then ignored, with no acknowledge and no register change, until the next START or STOP.
- R3: In a write, the first byte after the address loads the pointer and is acknowledged. Each following byte is acknowledged and written to the register at the pointer, and the pointer then steps by one.
- R4: In a read, the slave sends the byte at the pointer MSB first and changes SDA only while SCL is low. After a master acknowledge it sends the next byte. After a not-acknowledge it leaves SDA released.
- R5: The bank has five registers: count bytes at indices 0 to 3, least significant at 0, and the control byte at index 4. The pointer wraps from 4 to 0 on both reads and writes. A loaded value of 5 or more selects index 0. A read with no pointer byte starts at the pointer left by earlier traffic.
- R6: A repeated START ends the current transfer and returns the slave to address reception with no STOP in between, even after an ignored address.
- R7: When a read is addressed, the counter value is copied into a shadow. Count bytes of that read come from the shadow, so a tick during the read does not tear the value.
- R8: The counter steps by one on each clock with tick_i high while control bit 0 is 1. It holds while that bit is 0. A bus write to a count byte overrides the step in that cycle.
- R9: After reset the counter and control byte are zero. sda_oe_o is low after reset, after a STOP, and whenever the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| tick_i | input | 1 | Count enable pulse, one step per high cycle |
| sda_oe_o | output | 1 | Pull SDA low when 1, release when 0 |
| count_o | output | 32 | Live counter value |
| ctrl_o | output | 8 | Control byte, bit 0 enables counting |

## Verification
The bus function is tried with pointer writes that start at index 0 and at index 3. The second of these shows whether the pointer wraps into the control byte and back to the count. Reads are tried both with a pointer byte followed by a repeated START and with no pointer at all, which shows whether a stale pointer is kept. A foreign address followed by data tells a correctly ignoring slave from one that acknowledges or stores anyway. A repeated START straight after it shows whether the slave recovers without a STOP. A tick injected between bytes of a read, while the count sits just below a carry into byte 1, separates a shadowed read from a live one.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
   typedef enum logic [2:0] {
      LK_IDLE,
      LK_ADDR,
      LK_AACK,
      LK_WBYTE,
      LK_WACK,
      LK_RBYTE,
      LK_RACK,
      LK_IGN
   } link_st_t;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cp_sync.sv
module i2cp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int NLINES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2cp_sync: STAGES must be at least 2");
   end

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] lvl;
   logic [NLINES-1:0] lvl_q;

   assign raw = {sda_i, scl_i};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '1;
         else        chain <= {chain[STAGES-2:0], raw[g]};
      end
      assign lvl[g] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '1;
      else        lvl_q <= lvl;
   end

   assign scl_lvl   = lvl[0];
   assign sda_lvl   = lvl[1];
   assign scl_rise  = lvl[0] & ~lvl_q[0];
   assign scl_fall  = ~lvl[0] & lvl_q[0];
   assign start_det = lvl[0] & lvl_q[0] & lvl_q[1] & ~lvl[1];
   assign stop_det  = lvl[0] & lvl_q[0] & ~lvl_q[1] & lvl[1];
endmodule

// File: rtl/i2cp_link.sv
module i2cp_link
   import i2cp_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'b1101000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_lvl,
   input  logic              sda_lvl,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [BYTE_W-1:0] rd_byte,
   output logic              sda_oe,
   output logic              ptr_load,
   output logic              wr_stb,
   output logic [BYTE_W-1:0] wr_byte,
   output logic              rd_adv,
   output logic              snap
);
   link_st_t          st;
   logic [3:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txsh;
   logic              rw;
   logic              first;
   logic              mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= LK_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         txsh     <= '0;
         rw       <= 1'b0;
         first    <= 1'b0;
         mack     <= 1'b0;
         sda_oe   <= 1'b0;
         ptr_load <= 1'b0;
         wr_stb   <= 1'b0;
         wr_byte  <= '0;
         rd_adv   <= 1'b0;
         snap     <= 1'b0;
      end else begin
         ptr_load <= 1'b0;
         wr_stb   <= 1'b0;
         rd_adv   <= 1'b0;
         snap     <= 1'b0;
         if (stop_det) begin
            st     <= LK_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            st     <= LK_ADDR;
            bitcnt <= '0;
            first  <= 1'b1;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               LK_ADDR, LK_WBYTE: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     if (st == LK_ADDR) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                           sda_oe <= 1'b1;
                           rw     <= shreg[0];
                           snap   <= shreg[0];
                           st     <= LK_AACK;
                        end else begin
                           st <= LK_IGN;
                        end
                     end else begin
                        sda_oe  <= 1'b1;
                        wr_byte <= shreg;
                        first   <= 1'b0;
                        if (first) ptr_load <= 1'b1;
                        else       wr_stb   <= 1'b1;
                        st <= LK_WACK;
                     end
                  end
               end
               LK_AACK, LK_WACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (st == LK_AACK && rw) begin
                        txsh   <= rd_byte;
                        sda_oe <= ~rd_byte[7];
                        st     <= LK_RBYTE;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= LK_WBYTE;
                     end
                  end
               end
               LK_RBYTE: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        rd_adv <= 1'b1;
                        st     <= LK_RACK;
                     end else begin
                        txsh   <= {txsh[BYTE_W-2:0], 1'b0};
                        sda_oe <= ~txsh[6];
                        bitcnt <= bitcnt + 4'd1;
                     end
                  end
               end
               LK_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        txsh   <= rd_byte;
                        sda_oe <= ~rd_byte[7];
                        bitcnt <= '0;
                        st     <= LK_RBYTE;
                     end else begin
                        st <= LK_IGN;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_AACK && scl_rise) |=> sda_oe) else $error("ack not held");       // R1
   AST_IGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_IGN) |-> !sda_oe) else $error("drive while ignoring");           // R2
   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe)) else $error("SDA moved with SCL high"); // R4
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == LK_IDLE) |-> !sda_oe) else $error("drive while idle");              // R9
endmodule

// File: rtl/i2cp_regs.sv
module i2cp_regs
   import i2cp_pkg::*;
#(
   parameter int CNT_BYTES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ptr_load,
   input  logic                      wr_stb,
   input  logic [BYTE_W-1:0]         wr_byte,
   input  logic                      rd_adv,
   input  logic                      snap,
   input  logic                      tick,
   output logic [BYTE_W-1:0]         rd_byte,
   output logic [CNT_BYTES*BYTE_W-1:0] count_o,
   output logic [BYTE_W-1:0]         ctrl_o
);
   localparam int NREG = CNT_BYTES + 1;
   localparam int PW   = $clog2(NREG);
   localparam int CW   = CNT_BYTES * BYTE_W;

   if (CNT_BYTES < 1 || CNT_BYTES > 8) begin : g_bad_bytes
      $error("i2cp_regs: CNT_BYTES must be 1 to 8");
   end

   logic [PW-1:0]     ptr;
   logic [CW-1:0]     count_q;
   logic [CW-1:0]     shadow;
   logic [BYTE_W-1:0] ctrl_q;
   logic [BYTE_W-1:0] view [NREG];
   logic              hit_cnt;
   logic [PW-1:0]     ptr_nxt;

   assign hit_cnt = wr_stb && (int'(ptr) < CNT_BYTES);
   assign ptr_nxt = (ptr == PW'(NREG - 1)) ? '0 : ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (ptr_load) begin
         ptr <= (int'(wr_byte) < NREG) ? PW'(wr_byte) : '0;
      end else if (wr_stb || rd_adv) begin
         ptr <= ptr_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (hit_cnt) begin
         count_q[int'(ptr)*BYTE_W +: BYTE_W] <= wr_byte;
      end else if (tick && ctrl_q[0]) begin
         count_q <= count_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   ctrl_q <= '0;
      else if (wr_stb && ptr == PW'(CNT_BYTES))     ctrl_q <= wr_byte;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    shadow <= '0;
      else if (snap) shadow <= count_q;
   end

   for (genvar g = 0; g < CNT_BYTES; g++) begin : g_view
      assign view[g] = shadow[g*BYTE_W +: BYTE_W];
   end
   assign view[CNT_BYTES] = ctrl_q;

   assign rd_byte = view[ptr];
   assign count_o = count_q;
   assign ctrl_o  = ctrl_q;

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr) < NREG) else $error("pointer out of bank");                       // R5
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(shadow)) else $error("shadow moved without snap");         // R7
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctrl_q[0] && !wr_stb) |=> count_q == $past(count_q) + 1'b1)
      else $error("count did not step");                                           // R8
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[0] && !wr_stb) |=> $stable(count_q)) else $error("count moved");   // R8
endmodule

// File: rtl/i2cp_slave.sv
module i2cp_slave
   import i2cp_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'b1101000,
   parameter int         CNT_BYTES   = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scl_i,
   input  logic                        sda_i,
   input  logic                        tick_i,
   output logic                        sda_oe_o,
   output logic [CNT_BYTES*BYTE_W-1:0] count_o,
   output logic [BYTE_W-1:0]           ctrl_o
);
   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic ptr_load, wr_stb, rd_adv, snap;
   logic [BYTE_W-1:0] wr_byte, rd_byte;

   i2cp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   i2cp_link #(.DEV_ADDR(DEV_ADDR)) u_link (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .rd_byte(rd_byte), .sda_oe(sda_oe_o),
      .ptr_load(ptr_load), .wr_stb(wr_stb), .wr_byte(wr_byte),
      .rd_adv(rd_adv), .snap(snap)
   );

   i2cp_regs #(.CNT_BYTES(CNT_BYTES)) u_regs (
      .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .wr_stb(wr_stb),
      .wr_byte(wr_byte), .rd_adv(rd_adv), .snap(snap), .tick(tick_i),
      .rd_byte(rd_byte), .count_o(count_o), .ctrl_o(ctrl_o)
   );

   AST_START_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o) else $error("SDA held after STOP");                  // R9
endmodule

// File: tb/i2cp_slave_test.sv
module i2cp_slave_test;
   localparam int Q = 10;
   localparam logic [6:0] DEV = 7'b1101000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda_low = 1'b0;
   logic tick = 1'b0;
   logic quiet = 1'b0;
   logic sda_oe;
   logic [31:0] count_o;
   logic [7:0]  ctrl_o;
   wire sda_bus = ~(m_sda_low | sda_oe);

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [31:0] mcnt = '0;
   logic [7:0]  mctrl = '0;
   int mptr = 0;

   always #2.5 clk = ~clk;

   i2cp_slave uut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .tick_i(tick), .sda_oe_o(sda_oe), .count_o(count_o), .ctrl_o(ctrl_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference model compared on every clock while the bus is quiet (R8, R9)
   always @(negedge clk) begin
      if (rst_n) cycles++;
      if (quiet) begin
         chk("R8 count", count_o, mcnt);
         chk("R8 ctrl", {24'd0, ctrl_o}, {24'd0, mctrl});
         chk("R9 released", {31'd0, sda_oe}, 32'd0);
      end
   end

   initial begin
      wait (cycles > 150000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   task automatic waitq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda_low = 1'b1; waitq(); m_scl = 1'b0; waitq();
   endtask

   task automatic bus_rstart();
      m_sda_low = 1'b0; waitq(); m_scl = 1'b1; waitq();
      m_sda_low = 1'b1; waitq(); m_scl = 1'b0; waitq();
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1; waitq(); m_scl = 1'b1; waitq();
      m_sda_low = 1'b0; waitq(); waitq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = ~b[i]; waitq(); m_scl = 1'b1; waitq(); waitq();
         m_scl = 1'b0; waitq();
      end
      m_sda_low = 1'b0; waitq(); m_scl = 1'b1; waitq();
      ack = ~sda_bus; waitq(); m_scl = 1'b0; waitq();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_sda_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         waitq(); m_scl = 1'b1; waitq(); b[i] = sda_bus; waitq();
         m_scl = 1'b0;
      end
      waitq(); m_sda_low = give_ack; waitq(); m_scl = 1'b1; waitq(); waitq();
      m_scl = 1'b0;
   endtask

   task automatic adv_ptr();
      mptr = (mptr == 4) ? 0 : mptr + 1;
   endtask

   task automatic model_write(logic [7:0] v);
      if (mptr < 4) mcnt[mptr*8 +: 8] = v;
      else          mctrl = v;
      adv_ptr();
   endtask

   function automatic logic [7:0] model_byte(logic [31:0] snapv);
      return (mptr < 4) ? snapv[mptr*8 +: 8] : mctrl;
   endfunction

   task automatic go_quiet();
      repeat (8) @(negedge clk);
      quiet = 1'b1;
   endtask

   // write: pointer byte then data bytes (R1, R3)
   task automatic wr_xfer(input logic [7:0] p, input logic [7:0] d[$]);
      logic ack;
      quiet = 1'b0;
      bus_start();
      send_byte({DEV, 1'b0}, ack); chk("R1 addr ack", {31'd0, ack}, 32'd1);
      send_byte(p, ack);           chk("R3 pointer ack", {31'd0, ack}, 32'd1);
      mptr = (p < 5) ? int'(p) : 0;
      foreach (d[i]) begin
         send_byte(d[i], ack);     chk("R3 data ack", {31'd0, ack}, 32'd1);
         model_write(d[i]);
      end
      bus_stop();
      go_quiet();
   endtask

   // read n bytes, optionally after pointer write and repeated START (R4, R5, R6)
   task automatic rd_xfer(input bit set_ptr, input logic [7:0] p, input int n, input string req);
      logic ack;
      logic [7:0] b;
      logic [31:0] snapv;
      quiet = 1'b0;
      bus_start();
      if (set_ptr) begin
         send_byte({DEV, 1'b0}, ack); chk("R1 addr ack", {31'd0, ack}, 32'd1);
         send_byte(p, ack);           chk("R3 pointer ack", {31'd0, ack}, 32'd1);
         mptr = (p < 5) ? int'(p) : 0;
         bus_rstart();
      end
      send_byte({DEV, 1'b1}, ack); chk("R6 read addr ack", {31'd0, ack}, 32'd1);
      snapv = mcnt;
      for (int i = 0; i < n; i++) begin
         recv_byte(i < n - 1, b);
         chk(req, {24'd0, b}, {24'd0, model_byte(snapv)});
         adv_ptr();
      end
      bus_stop();
      chk("R4 released after nack", {31'd0, sda_oe}, 32'd0);
      go_quiet();
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(posedge clk); if (mctrl[0]) mcnt = mcnt + 1;
      @(negedge clk); tick = 1'b0;
   endtask

   initial begin
      logic ack;
      logic [7:0] b;
      repeat (5) @(negedge clk);
      chk("R9 reset count", count_o, 32'd0);
      chk("R9 reset ctrl", {24'd0, ctrl_o}, 32'd0);
      chk("R9 reset oe", {31'd0, sda_oe}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      quiet = 1'b1;

      // R3: sequential write from index 0
      wr_xfer(8'd0, '{8'h11, 8'h22, 8'h33, 8'h44});
      chk("R3 count bytes", count_o, 32'h44332211);

      // R4: read from index 1 with pointer and repeated START
      rd_xfer(1'b1, 8'd1, 3, "R4 read data");

      // R5: write wraps through control byte back to index 0
      wr_xfer(8'd3, '{8'hAB, 8'h00, 8'h5A});
      chk("R5 wrapped write", count_o, 32'hAB33225A);
      // R5: read with stale pointer (index 1), wrapping past index 4
      rd_xfer(1'b0, 8'd0, 5, "R5 stale pointer read");
      // R5: out-of-range pointer selects index 0
      rd_xfer(1'b1, 8'd9, 2, "R5 large pointer read");

      // R2 and R6: foreign address ignored, repeated START recovers
      quiet = 1'b0;
      bus_start();
      send_byte({7'h51, 1'b0}, ack); chk("R2 no ack on foreign address", {31'd0, ack}, 32'd0);
      send_byte(8'h00, ack);         chk("R2 no ack while ignored", {31'd0, ack}, 32'd0);
      send_byte(8'h77, ack);         chk("R2 no ack while ignored", {31'd0, ack}, 32'd0);
      chk("R2 count untouched", count_o, mcnt);
      bus_rstart();
      send_byte({DEV, 1'b0}, ack);   chk("R6 ack after repeated START", {31'd0, ack}, 32'd1);
      send_byte(8'd0, ack);          chk("R6 pointer ack", {31'd0, ack}, 32'd1);
      mptr = 0;
      send_byte(8'h99, ack);         chk("R6 data ack", {31'd0, ack}, 32'd1);
      model_write(8'h99);
      bus_stop();
      go_quiet();
      chk("R6 write after recovery", count_o, 32'hAB332299);

      // R8: counting enabled, then held
      wr_xfer(8'd0, '{8'hFF, 8'h01, 8'h00, 8'h00, 8'h01});
      pulse_tick(); pulse_tick(); pulse_tick();
      chk("R8 counted three", count_o, 32'h00000202);
      wr_xfer(8'd0, '{8'hFF, 8'h01, 8'h00, 8'h00, 8'h01});

      // R7: tick between bytes of a read must not tear the value
      quiet = 1'b0;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd0, ack);
      bus_rstart();
      send_byte({DEV, 1'b1}, ack);   chk("R7 read addr ack", {31'd0, ack}, 32'd1);
      recv_byte(1'b1, b);            chk("R7 byte0", {24'd0, b}, 32'h000000FF);
      pulse_tick();
      recv_byte(1'b1, b);            chk("R7 byte1 from shadow", {24'd0, b}, 32'h00000001);
      recv_byte(1'b1, b);            chk("R7 byte2", {24'd0, b}, 32'd0);
      recv_byte(1'b0, b);            chk("R7 byte3", {24'd0, b}, 32'd0);
      bus_stop();
      mptr = 4;
      go_quiet();
      chk("R7 live count moved", count_o, 32'h00000200);

      // R8: control bit 0 clear holds the count
      wr_xfer(8'd4, '{8'h00});
      pulse_tick(); pulse_tick();
      chk("R8 held with enable clear", count_o, 32'h00000200);

      repeat (20) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule